// File: doc/BRIEF.md
# Bitwise Truth-Table Logic Unit

This block is the logic half of an ALU datapath. Instead of a fixed menu of logic operations, it takes a small truth-table immediate and evaluates it independently at every bit position. The operand bits at a position form the index, and the selected table bit becomes the result bit at that position. Every two-input or three-input boolean function of the operands is therefore a single operation, selected only by the table value.

The table is fanned out in groups to every bit lane, so the same table drives all lanes. Each lane is a small multiplexer. In two-input mode, the lane selects one of four table bits using the pair {x, y}. In three-input mode, it selects one of eight table bits using the triple {x, y, z}. In both cases x is the most significant select bit. The result and a valid flag are registered, and an operation whose strobe is low leaves the previous result in place.

Top module: `lut_logic_unit`

## Requirements
- R1: `valid_o` is low after reset and equals `valid_i` from the previous clock edge. `result_o` is all zeros after reset.
- R2: When `mode3_i`=0, bit i of the result captured on a strobed edge is `table_i[2*x_i[i] + y_i[i]]`.
- R3: When `mode3_i`=1, bit i of the result is `table_i[4*x_i[i] + 2*y_i[i] + z_i[i]]`.
- R4: When `mode3_i`=0, the values of `z_i` and `table_i[7:4]` have no effect on the result.
- R5: In two-input mode, code 4'b0000 gives all zeros (clear) and code 4'b1111 gives all ones.
- R6: In two-input mode, code 4'b0101 gives ~y (NOT), code 4'b1010 gives y, and code 4'b1100 gives x (move).
- R7: In two-input mode, 4'b1000 gives x&y, 4'b1110 gives x|y, 4'b0110 gives x^y, 4'b0100 gives x&~y, and 4'b0010 gives y&~x (the reversed operand order).
- R8: An edge with `valid_i`=0 leaves `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode3_i | input | 1 | 1 selects three-input mode, 0 selects two-input mode |
| table_i | input | 8 | Truth-table immediate; only bits 3:0 are used in two-input mode |
| x_i | input | 64 | Operand x, the most significant select bit |
| y_i | input | 64 | Operand y |
| z_i | input | 64 | Operand z, the least significant select bit in three-input mode |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result valid, one cycle after the strobe |

## Verification
The hardest case to reach from the ports is a lane selecting a specific table entry under a specific table value. A table bit that is wired wrongly only appears when some lane's operand bits index that exact entry, and only when the table value makes that entry differ from its neighbours. The stimulus therefore sweeps all 16 two-input codes and all 256 three-input codes, each with random 64-bit operands so that every index pattern occurs in many lanes. For the ignored inputs, the same x, y and low table nibble are applied again with z and the high nibble changed, and the two results must match.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef logic [7:0] tbl_t;

  localparam logic [3:0] OP_CLEAR = 4'b0000;
  localparam logic [3:0] OP_SET   = 4'b1111;
  localparam logic [3:0] OP_NOT_Y = 4'b0101;
  localparam logic [3:0] OP_MOV_Y = 4'b1010;
  localparam logic [3:0] OP_MOV_X = 4'b1100;
  localparam logic [3:0] OP_AND   = 4'b1000;
  localparam logic [3:0] OP_OR    = 4'b1110;
  localparam logic [3:0] OP_XOR   = 4'b0110;
  localparam logic [3:0] OP_ANDN  = 4'b0100;  // x & ~y
  localparam logic [3:0] OP_NANDR = 4'b0010;  // y & ~x
endpackage

// File: rtl/lut_tbl_bcast.sv
module lut_tbl_bcast
  import lut_pkg::*;
#(
  parameter int N_GROUPS = 8
) (
  input  tbl_t tbl_i,
  input  logic mode3_i,
  output tbl_t grp_tbl_o [N_GROUPS]
);
  tbl_t tbl_eff;

  // zero upper nibble in 2-input mode so unused lanes do not toggle
  always_comb begin
    tbl_eff = tbl_i;
    if (!mode3_i) tbl_eff[7:4] = 4'b0000;
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign grp_tbl_o[g] = tbl_eff;
  end
endmodule

// File: rtl/lut_bit_mux.sv
module lut_bit_mux
  import lut_pkg::*;
(
  input  tbl_t tbl_i,
  input  logic mode3_i,
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic r_o
);
  logic [1:0] pair;
  logic       sel4;

  // first level: {x,y} picks a pair (3-input) or a single bit (2-input)
  always_comb begin
    unique case ({x_i, y_i})
      2'b00:   begin pair = tbl_i[1:0]; sel4 = tbl_i[0]; end
      2'b01:   begin pair = tbl_i[3:2]; sel4 = tbl_i[1]; end
      2'b10:   begin pair = tbl_i[5:4]; sel4 = tbl_i[2]; end
      default: begin pair = tbl_i[7:6]; sel4 = tbl_i[3]; end
    endcase
  end

  assign r_o = mode3_i ? (z_i ? pair[1] : pair[0]) : sel4;
endmodule

// File: rtl/lut_logic_unit.sv
module lut_logic_unit
  import lut_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int GROUP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode3_i,
  input  logic [7:0]        table_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] z_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  localparam int N_GROUPS = DATA_W / GROUP_W;

  tbl_t              grp_tbl [N_GROUPS];
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;
  logic              vld_q;

  lut_tbl_bcast #(.N_GROUPS(N_GROUPS)) u_bcast (
    .tbl_i     (table_i),
    .mode3_i   (mode3_i),
    .grp_tbl_o (grp_tbl)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    lut_bit_mux u_mux (
      .tbl_i   (grp_tbl[i / GROUP_W]),
      .mode3_i (mode3_i),
      .x_i     (x_i[i]),
      .y_i     (y_i[i]),
      .z_i     (z_i[i]),
      .r_o     (res_d[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;
endmodule

// File: rtl/lut_logic_unit_chk.sv
module lut_logic_unit_chk
  import lut_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode3_i,
  input logic [7:0]        table_i,
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] y_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o
);
  a_r1_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode3_i && table_i[3:0] == OP_CLEAR) |=> (result_o == '0));
  a_r7_and: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode3_i && table_i[3:0] == OP_AND) |=> (result_o == $past(x_i & y_i)));
  a_r6_not: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode3_i && table_i[3:0] == OP_NOT_Y) |=> (result_o == ~$past(y_i)));
  a_r3_move_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode3_i && table_i == 8'hF0) |=> (result_o == $past(x_i)));
endmodule

bind lut_logic_unit lut_logic_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mode3_i  (mode3_i),
  .table_i  (table_i),
  .x_i      (x_i),
  .y_i      (y_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/tb_lut_logic_unit.sv
`timescale 1ns/1ps
module tb_lut_logic_unit;
  import lut_pkg::*;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic         mode3 = 1'b0;
  logic [7:0]   tbl = '0;
  logic [W-1:0] x = '0, y = '0, z = '0;
  logic [W-1:0] res;
  logic         vld;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  lut_logic_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode3_i(mode3),
    .table_i(tbl), .x_i(x), .y_i(y), .z_i(z), .result_o(res), .valid_o(vld)
  );

  function automatic logic [W-1:0] model(input logic m3, input logic [7:0] t,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int idx;
      if (m3) idx = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
      else    idx = 2 * int'(a[i]) + int'(b[i]);
      r[i] = t[idx];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
      input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // drive one strobed operation at negedge, sample one cycle later at negedge
  task automatic run_op(input logic m3, input logic [7:0] t, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [W-1:0] c, input logic [W-1:0] exp,
      input string req);
    @(negedge clk);
    valid = 1'b1; mode3 = m3; tbl = t; x = a; y = b; z = c;
    @(negedge clk);
    valid = 1'b0;
    check(res == exp, req, res, exp);
    check(vld == 1'b1, "R1 valid", {63'b0, vld}, 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, c, held, r_first;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(res == '0, "R1 reset result", res, '0);
    check(vld == 1'b0, "R1 reset valid", {63'b0, vld}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vld == 1'b0, "R1 idle valid", {63'b0, vld}, '0);

    // named codes in 2-input mode, several operand patterns
    for (int p = 0; p < 4; p++) begin
      a = (p == 0) ? 64'hFFFF_0000_FFFF_0000 : rnd64();
      b = (p == 0) ? 64'hFF00_FF00_FF00_FF00 : rnd64();
      c = rnd64();
      run_op(0, {4'hA, OP_CLEAR}, a, b, c, '0, "R5 clear");
      run_op(0, {4'h3, OP_SET},   a, b, c, '1, "R5 set");
      run_op(0, {4'h0, OP_NOT_Y}, a, b, c, ~b, "R6 not");
      run_op(0, {4'h0, OP_MOV_Y}, a, b, c, b, "R6 move y");
      run_op(0, {4'h0, OP_MOV_X}, a, b, c, a, "R6 move x");
      run_op(0, {4'h0, OP_AND},   a, b, c, a & b, "R7 and");
      run_op(0, {4'h0, OP_OR},    a, b, c, a | b, "R7 or");
      run_op(0, {4'h0, OP_XOR},   a, b, c, a ^ b, "R7 xor");
      run_op(0, {4'h0, OP_ANDN},  a, b, c, a & ~b, "R7 andnot");
      run_op(0, {4'h0, OP_NANDR}, a, b, c, b & ~a, "R7 reversed andnot");
    end

    // R2 sweep all 4-bit codes
    for (int t = 0; t < 16; t++) begin
      a = rnd64(); b = rnd64(); c = rnd64();
      run_op(0, 8'(t), a, b, c, model(0, 8'(t), a, b, c), "R2 sweep");
    end

    // R3 sweep all 8-bit codes
    for (int t = 0; t < 256; t++) begin
      a = rnd64(); b = rnd64(); c = rnd64();
      run_op(1, 8'(t), a, b, c, model(1, 8'(t), a, b, c), "R3 sweep");
    end
    run_op(1, 8'hF0, a, b, c, a, "R3 move x");
    run_op(1, 8'hAA, a, b, c, c, "R3 move z");

    // R4 z and upper nibble ignored in 2-input mode
    for (int p = 0; p < 8; p++) begin
      logic [3:0] lo;
      a = rnd64(); b = rnd64(); c = rnd64();
      lo = 4'($urandom());
      run_op(0, {4'h0, lo}, a, b, c, model(0, {4'h0, lo}, a, b, c), "R4 base");
      r_first = res;
      run_op(0, {4'($urandom()) | 4'h1, lo}, a, b, ~c, r_first, "R4 z/upper ignored");
    end

    // R8 hold with valid low and changing inputs
    held = res;
    @(negedge clk);
    valid = 1'b0; mode3 = 1'b1; tbl = 8'h5C; x = rnd64(); y = rnd64(); z = rnd64();
    @(negedge clk);
    check(res == held, "R8 hold", res, held);
    check(vld == 1'b0, "R1 valid low", {63'b0, vld}, '0);
    @(negedge clk);
    tbl = 8'hFF;
    @(negedge clk);
    check(res == held, "R8 hold 2", res, held);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule